// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This block moves the data of one disk command between system memory and a sector-addressed disk stream by walking a table of region descriptors held in memory. The device state machine first arms the engine with the command's sector count, its starting sector and its direction. It then hands over the table's base address with a go pulse. The engine fetches one 8-byte descriptor at a time. It waits a modelled disk latency and then issues memory bursts that cover the descriptor's byte range, cut so that no burst crosses a page boundary.

The memory port is a simple request port. A request counts as accepted in any cycle where `mem_busy` is low. When `mem_busy` is high, the engine withdraws and retries the same request after a fixed pause. A descriptor whose end-of-table bit is set closes the command. The engine then gives a one-cycle `done` pulse, and `err` marks whether the byte accounting failed or an abort occurred.

Top module: `sgdma_engine`

## Requirements
- R1: After a synchronous reset, `phase` is 0 (idle), `mem_req` is low, `done` and `err` are low and `sector` is 0.
- R2: `arm` is accepted only in idle. It moves `phase` to 1 and latches the direction, the starting sector and the byte budget (sector count × 512, with a count of 0 meaning 256 sectors). `go` is accepted only when `phase` is 1. Either pulse at any other time has no effect.
- R3: On `go`, the descriptor pointer is the table address with bits [2:0] cleared. Each descriptor fetch is a memory read of length 8 at the pointer, and the pointer then advances by 8. The returned word carries the base address in bits [31:0], with bit 0 ignored, the byte count in bits [47:32], with 0 meaning 65536, and the end-of-table flag in bit 63.
- R4: Each data burst has length min(bytes left in descriptor, PAGE_BYTES), reduced to the distance to the next page boundary if it would cross one. Successive bursts of a descriptor are contiguous.
- R5: A request seen with `mem_busy` high is withdrawn for exactly BACKOFF_CYC cycles and then re-issued with the same address and length.
- R6: Descriptor fetches are reads (`mem_wr`=0). Data bursts are writes to memory when the armed direction is disk-to-memory and reads otherwise.
- R7: The first burst of a descriptor is requested DISK_LAT + (byte count / 512) cycles after the cycle in which the descriptor arrives.
- R8: `sector` holds the armed starting sector and increases by byte count / 512 when each descriptor is accepted, wrapping at LBA_W bits.
- R9: A descriptor whose byte count exceeds the remaining byte budget ends the command at once with `done` and `err`, and no burst is issued for it.
- R10: After the last burst of an end-of-table descriptor, `done` pulses with `err` low if the budget is exactly used up and high otherwise. Without end-of-table, the next descriptor is fetched.
- R11: `abort` while `phase` is not 0 returns the engine to idle and gives `done` with `err` in the next cycle.
- R12: `done` is a single-cycle pulse, and `phase` is 0 whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm pulse from the device state machine |
| arm_to_mem | input | 1 | 1 = disk-to-memory (disk read), 0 = memory-to-disk |
| arm_sectors | input | 8 | Command sector count, 0 = 256 |
| arm_lba | input | LBA_W | Starting sector number |
| go | input | 1 | Start pulse carrying the table address |
| go_table | input | 32 | Descriptor table address |
| abort | input | 1 | Abort from the device state machine |
| mem_req | output | 1 | Memory request valid |
| mem_wr | output | 1 | 1 = write to memory |
| mem_addr | output | 32 | Request address |
| mem_len | output | PAGE_SHIFT+1 | Request length in bytes |
| mem_busy | input | 1 | Memory port busy, request not taken |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data (descriptor word) |
| phase | output | 2 | 0 idle, 1 armed, 2 transferring |
| sector | output | LBA_W | Current sector number |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Error qualifier of `done` |

## Verification
A behavioural model in the bench tracks the engine clock by clock and compares every output against it. Four kinds of table are used. A single page-aligned descriptor checks latency and pointer stepping. A two-entry table has one range straddling a page edge and one zero-count (maximum) range under random bus-busy. This separates correct page splitting and retry from off-by-one cuts or lost retries. The remaining tables are a descriptor larger than the budget and an end-of-table with budget left over, which separate the two error paths from a clean finish. Aborts during the armed and delay phases, together with stray `arm` and `go` pulses, show which inputs are ignored.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int ADDR_W       = 32;
    localparam int DESC_W       = 64;
    localparam int DESC_BYTES   = 8;
    localparam int SECTOR_SHIFT = 9;
    localparam int CNT_W        = 16;
    localparam int REM_W        = CNT_W + 1;
    localparam int CMD_W        = 8 + 1 + SECTOR_SHIFT;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_FETCH,
        S_FWAIT,
        S_DELAY,
        S_BURST,
        S_BACKOFF
    } eng_st_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic              last;
        logic [14:0]       unused;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] base;
    } desc_t;

    function automatic phase_e phase_of(eng_st_e s);
        case (s)
            S_IDLE:  return PH_IDLE;
            S_ARMED: return PH_ARMED;
            default: return PH_RUN;
        endcase
    endfunction

    function automatic logic [REM_W-1:0] desc_bytes(logic [CNT_W-1:0] c);
        return (c == '0) ? REM_W'(1 << CNT_W) : {1'b0, c};
    endfunction

    function automatic logic [CMD_W-1:0] cmd_budget(logic [7:0] secs);
        logic [8:0] n;
        n = (secs == 8'd0) ? 9'd256 : {1'b0, secs};
        return {n, {SECTOR_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/sgdma_countdown.sv
module sgdma_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sgdma_burst_split.sv
module sgdma_burst_split
    import sgdma_pkg::*;
#(
    parameter int PAGE_BYTES = 8192,
    localparam int PS        = $clog2(PAGE_BYTES),
    localparam int LEN_W     = PS + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REM_W-1:0]  left,
    output logic [LEN_W-1:0]  len
);
    logic [REM_W-1:0] room;
    logic [REM_W-1:0] cap;
    logic [REM_W-1:0] pick;

    always_comb begin
        room = REM_W'(PAGE_BYTES) - REM_W'(addr[PS-1:0]);
        cap  = (left > REM_W'(PAGE_BYTES)) ? REM_W'(PAGE_BYTES) : left;
        pick = (cap > room) ? room : cap;
        len  = LEN_W'(pick);
    end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int PAGE_BYTES  = 8192,
    parameter int BACKOFF_CYC = 4,
    parameter int DISK_LAT    = 6,
    parameter int LBA_W       = 28,
    localparam int PS         = $clog2(PAGE_BYTES),
    localparam int LEN_W      = PS + 1,
    localparam int BO_W       = $clog2(BACKOFF_CYC + 1) + 1,
    localparam int DLY_W      = $clog2(DISK_LAT + 130) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               arm_to_mem,
    input  logic [7:0]         arm_sectors,
    input  logic [LBA_W-1:0]   arm_lba,
    input  logic               go,
    input  logic [ADDR_W-1:0]  go_table,
    input  logic               abort,
    output logic               mem_req,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    input  logic               mem_busy,
    input  logic               mem_rvalid,
    input  logic [DESC_W-1:0]  mem_rdata,
    output logic [1:0]         phase,
    output logic [LBA_W-1:0]   sector,
    output logic               done,
    output logic               err
);
    eng_st_e           state;
    logic              back_to_fetch;
    logic              to_mem;
    logic              last_desc;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] cur_addr;
    logic [REM_W-1:0]  left;
    logic [CMD_W-1:0]  budget;
    logic [LEN_W-1:0]  blen;

    desc_t             dsc;
    logic [REM_W-1:0]  dsc_bytes;
    logic [8:0]        dsc_secs;

    logic              bo_load, bo_zero;
    logic              dly_load, dly_zero;
    logic [DLY_W-1:0]  dly_val;

    always_comb begin
        dsc       = desc_t'(mem_rdata);
        dsc_bytes = desc_bytes(dsc.count);
        dsc_secs  = 9'(dsc_bytes >> SECTOR_SHIFT);
        dly_val   = DLY_W'(DISK_LAT - 1) + DLY_W'(dsc_secs);
    end

    sgdma_burst_split #(.PAGE_BYTES(PAGE_BYTES)) u_split (
        .addr (cur_addr),
        .left (left),
        .len  (blen)
    );

    assign bo_load  = mem_req && mem_busy;
    assign dly_load = (state == S_FWAIT) && mem_rvalid;

    sgdma_countdown #(.W(BO_W)) u_backoff (
        .clk      (clk),
        .rst      (rst),
        .load     (bo_load),
        .load_val (BO_W'(BACKOFF_CYC - 1)),
        .zero     (bo_zero)
    );

    sgdma_countdown #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    always_comb begin
        mem_req  = (state == S_FETCH) || (state == S_BURST);
        mem_wr   = (state == S_BURST) && to_mem;
        mem_addr = (state == S_FETCH) ? ptr : cur_addr;
        mem_len  = (state == S_FETCH) ? LEN_W'(DESC_BYTES) : blen;
        phase    = phase_of(state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            back_to_fetch <= 1'b0;
            to_mem        <= 1'b0;
            last_desc     <= 1'b0;
            ptr           <= '0;
            cur_addr      <= '0;
            left          <= '0;
            budget        <= '0;
            sector        <= '0;
            done          <= 1'b0;
            err           <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (abort && state != S_IDLE) begin
                state <= S_IDLE;
                done  <= 1'b1;
                err   <= 1'b1;
            end else begin
                unique case (state)
                    S_IDLE: if (arm) begin
                        state  <= S_ARMED;
                        to_mem <= arm_to_mem;
                        budget <= cmd_budget(arm_sectors);
                        sector <= arm_lba;
                    end
                    S_ARMED: if (go) begin
                        ptr   <= {go_table[ADDR_W-1:3], 3'b000};
                        state <= S_FETCH;
                    end
                    S_FETCH: begin
                        if (mem_busy) begin
                            state         <= S_BACKOFF;
                            back_to_fetch <= 1'b1;
                        end else begin
                            state <= S_FWAIT;
                        end
                    end
                    S_FWAIT: if (mem_rvalid) begin
                        ptr <= ptr + ADDR_W'(DESC_BYTES);
                        if (CMD_W'(dsc_bytes) > budget) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                            err   <= 1'b1;
                        end else begin
                            budget    <= budget - CMD_W'(dsc_bytes);
                            sector    <= sector + LBA_W'(dsc_secs);
                            cur_addr  <= {dsc.base[ADDR_W-1:1], 1'b0};
                            left      <= dsc_bytes;
                            last_desc <= dsc.last;
                            state     <= S_DELAY;
                        end
                    end
                    S_DELAY: if (dly_zero) state <= S_BURST;
                    S_BURST: begin
                        if (mem_busy) begin
                            state         <= S_BACKOFF;
                            back_to_fetch <= 1'b0;
                        end else begin
                            cur_addr <= cur_addr + ADDR_W'(blen);
                            left     <= left - REM_W'(blen);
                            if (left == REM_W'(blen)) begin
                                if (last_desc) begin
                                    state <= S_IDLE;
                                    done  <= 1'b1;
                                    err   <= (budget != '0);
                                end else begin
                                    state <= S_FETCH;
                                end
                            end
                        end
                    end
                    S_BACKOFF: if (bo_zero)
                        state <= back_to_fetch ? S_FETCH : S_BURST;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R4: a data burst never reaches past the end of its page and is never empty
    assert_page_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_BURST) |->
            ((LEN_W'(mem_addr[PS-1:0]) + mem_len) <= LEN_W'(PAGE_BYTES)) && (mem_len != '0));

    // R5: a request refused by a busy port is withdrawn in the next cycle
    assert_busy_withdraw_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_busy) |=> !mem_req);

    // R11: abort in a non-idle phase finishes with an error one cycle later
    assert_abort_err_R11: assert property (@(posedge clk) disable iff (rst)
        (abort && phase != PH_IDLE) |=> (done && err && phase == PH_IDLE));

    // R12: done lasts one cycle
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: the engine is idle whenever done is shown
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE && !mem_req));

    // R9: an over-budget descriptor never reaches the burst stage
    assert_overrun_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_FWAIT && mem_rvalid && CMD_W'(dsc_bytes) > budget && !abort)
            |=> (done && err));
endmodule

// File: tb/sgdma_engine_bench.sv
module sgdma_engine_bench;
    localparam int PAGE  = 8192;
    localparam int BOFF  = 4;
    localparam int LAT   = 6;
    localparam int LBAW  = 28;
    localparam int LENW  = $clog2(PAGE) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm = 1'b0, arm_to_mem = 1'b0;
    logic [7:0]       arm_sectors = '0;
    logic [LBAW-1:0]  arm_lba = '0;
    logic             go = 1'b0;
    logic [31:0]      go_table = '0;
    logic             abort = 1'b0;
    logic             mem_req, mem_wr;
    logic [31:0]      mem_addr;
    logic [LENW-1:0]  mem_len;
    logic             mem_busy = 1'b0;
    logic             mem_rvalid = 1'b0;
    logic [63:0]      mem_rdata = '0;
    logic [1:0]       phase;
    logic [LBAW-1:0]  sector;
    logic             done, err;

    always #4 clk = ~clk;

    sgdma_engine #(.PAGE_BYTES(PAGE), .BACKOFF_CYC(BOFF), .DISK_LAT(LAT), .LBA_W(LBAW)) u_sgdma_engine (
        .clk, .rst, .arm, .arm_to_mem, .arm_sectors, .arm_lba, .go, .go_table, .abort,
        .mem_req, .mem_wr, .mem_addr, .mem_len, .mem_busy, .mem_rvalid, .mem_rdata,
        .phase, .sector, .done, .err
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // descriptor memory
    logic [63:0] dtab [64];
    logic        busy_en = 1'b0;
    logic        rd_acc;

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [15:0] cnt, input logic last);
        return {last, 15'd0, cnt, base};
    endfunction

    always @(negedge clk) rd_acc = mem_req && !mem_busy && !mem_wr;

    always @(posedge clk) begin
        logic        acc;
        logic [31:0] a;
        acc = rd_acc;
        a   = mem_addr;
        #2;
        mem_rvalid = acc;
        mem_rdata  = acc ? dtab[(a >> 3) & 63] : 64'd0;
        mem_busy   = busy_en && (($urandom % 3) == 0);
    end

    // behavioural reference: 0 idle 1 armed 2 fetch 3 wait 4 delay 5 burst 6 backoff
    int     m_st, m_ret, m_dly, m_bo;
    longint m_ptr, m_addr, m_rem, m_left, m_sec;
    bit     m_tomem, m_last, m_done, m_err;

    function automatic longint exp_len(input longint a, input longint r);
        longint l;
        l = (r < PAGE) ? r : PAGE;
        if ((a / PAGE) != ((a + l - 1) / PAGE)) l = PAGE - (a % PAGE);
        return l;
    endfunction

    always @(posedge clk) begin
        bit was_done;
        was_done = 0;
        m_done = 0;
        m_err  = 0;
        if (rst) begin
            m_st = 0; m_sec = 0;
        end else if (abort && m_st != 0) begin
            m_st = 0; m_done = 1; m_err = 1;
        end else begin
            case (m_st)
                0: if (arm) begin
                    m_st = 1; m_tomem = arm_to_mem; m_sec = arm_lba;
                    m_left = (arm_sectors == 0 ? 256 : arm_sectors) * 512;
                end
                1: if (go) begin m_st = 2; m_ptr = go_table & 32'hFFFF_FFF8; end
                2: if (mem_busy) begin m_st = 6; m_ret = 2; m_bo = BOFF; end else m_st = 3;
                3: if (mem_rvalid) begin
                    longint n;
                    n = mem_rdata[47:32];
                    if (n == 0) n = 65536;
                    m_ptr = (m_ptr + 8) % 64'h1_0000_0000;
                    if (n > m_left) begin m_st = 0; m_done = 1; m_err = 1; end
                    else begin
                        m_left -= n;
                        m_sec  = (m_sec + n / 512) % (64'd1 << LBAW);
                        m_addr = mem_rdata[31:0] & 32'hFFFF_FFFE;
                        m_rem  = n; m_last = mem_rdata[63];
                        m_dly  = LAT + n / 512; m_st = 4;
                    end
                end
                4: begin m_dly--; if (m_dly == 0) m_st = 5; end
                5: if (mem_busy) begin m_st = 6; m_ret = 5; m_bo = BOFF; end
                   else begin
                    longint l;
                    l = exp_len(m_addr, m_rem);
                    m_addr += l; m_rem -= l;
                    if (m_rem == 0) begin
                        if (m_last) begin m_st = 0; m_done = 1; m_err = (m_left != 0); end
                        else m_st = 2;
                    end
                end
                6: begin m_bo--; if (m_bo == 0) m_st = m_ret; end
                default: m_st = 0;
            endcase
        end
    end

    // compare every clock
    bit     saw_done, saw_err;
    int     bursts;
    always @(negedge clk) begin
        if (!rst) begin
            int  ph;
            bit  rq;
            ph = (m_st == 0) ? 0 : (m_st == 1) ? 1 : 2;
            rq = (m_st == 2 || m_st == 5);
            check("R2 phase", phase, ph);
            check("R5 mem_req", mem_req, rq);
            check("R8 sector", sector, m_sec);
            check("R10 done", done, m_done);
            check("R10 err", err, m_err);
            if (rq && mem_req) begin
                check("R3 R4 mem_addr", mem_addr, (m_st == 2) ? m_ptr : m_addr);
                check("R3 R4 mem_len", mem_len, (m_st == 2) ? 8 : exp_len(m_addr, m_rem));
                check("R6 mem_wr", mem_wr, (m_st == 5) ? m_tomem : 0);
            end
            if (mem_req && mem_len != 8 && !mem_busy) bursts++;
            if (done) begin saw_done = 1; saw_err = err; end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_arm(input bit tm, input logic [7:0] secs, input logic [LBAW-1:0] lba);
        tick(1); arm = 1; arm_to_mem = tm; arm_sectors = secs; arm_lba = lba;
        tick(1); arm = 0;
    endtask

    task automatic do_go(input logic [31:0] t);
        tick(1); go = 1; go_table = t;
        tick(1); go = 0;
    endtask

    task automatic wait_done;
        saw_done = 0;
        while (!saw_done) tick(1);
        tick(2);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) dtab[i] = '0;
        tick(3);
        #1;
        check("R1 phase", phase, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 done", done, 0);
        check("R1 sector", sector, 0);
        rst = 0;
        tick(2);

        // R2: go without arm is ignored
        do_go(32'h0000_1000);
        tick(3);
        check("R2 go ignored", phase, 0);

        // R3 R7 R10: single aligned descriptor, clean finish; stray arm ignored
        dtab[0] = mk_desc(32'h4000_0000, 16'd1024, 1'b1);
        do_arm(1'b0, 8'd2, 28'h100);
        do_go(32'h0000_1005);
        tick(2);
        do_arm(1'b1, 8'd9, 28'h777);
        bursts = 0;
        wait_done();
        check("R10 clean finish err", saw_err, 0);
        check("R8 sector after", sector, 28'h102);
        check("R4 single burst", bursts, 1);

        // R4 R5 R6: page straddle and max-count descriptor under busy
        dtab[32] = mk_desc(32'h2000_1F01, 16'h0400, 1'b0);
        dtab[33] = mk_desc(32'h3000_0000, 16'h0000, 1'b1);
        busy_en = 1;
        bursts = 0;
        do_arm(1'b1, 8'd130, 28'hFFF_FFF0);
        do_go(32'h0000_1100);
        wait_done();
        busy_en = 0;
        check("R10 two-entry err", saw_err, 0);
        check("R4 burst count", bursts, 10);
        check("R8 sector wrap", sector, 28'h000_0072);

        // R9: descriptor larger than budget
        dtab[0] = mk_desc(32'h5000_0000, 16'd1024, 1'b1);
        bursts = 0;
        do_arm(1'b0, 8'd1, 28'h10);
        do_go(32'h0000_1000);
        wait_done();
        check("R9 overrun err", saw_err, 1);
        check("R9 no bursts", bursts, 0);

        // R10: end of table with budget left
        do_arm(1'b0, 8'd4, 28'h20);
        do_go(32'h0000_1000);
        wait_done();
        check("R10 leftover err", saw_err, 1);

        // R11: abort in armed phase and in delay
        do_arm(1'b0, 8'd2, 28'h0);
        tick(1); abort = 1; tick(1); abort = 0;
        tick(1);
        check("R11 armed abort err", saw_err, 1);
        check("R11 armed abort phase", phase, 0);
        dtab[0] = mk_desc(32'h6000_0000, 16'd1024, 1'b1);
        do_arm(1'b0, 8'd2, 28'h0);
        do_go(32'h0000_1000);
        tick(6); abort = 1; tick(1); abort = 0;
        tick(2);
        check("R11 delay abort err", saw_err, 1);
        check("R12 idle after abort", phase, 0);

        tick(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule